// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block sits after three 8-bit colour converters. It receives one pixel per clock: a red, a green and a blue code in straight binary, each with its own out-of-range flag. It places the pixel stream on one or two 24-bit output ports, A and B. Each port carries its data together with the three out-of-range flags of the pixel it holds.

Four static configuration inputs select the mode:
- dual-port or single-port operation;
- which port receives the odd pixels;
- whether the two ports change on the same edge or on alternate edges;
- whether data is zeroed while the line-sync or clamp pulse is active.

An active-low output-enable input is reflected on a registered drive flag. When that flag is 0, downstream pads are to treat the ports as high impedance. A half-rate phase output marks the position of each pixel pair.

Pixel parity restarts at every rising edge of the line-sync input. This lets a receiver rebuild the pixel order from the two ports without further signalling.

Top module: `pix_demux_top`

## Requirements
- R1: While `rst` is high, every data and flag output, `half_clk` and `out_drv` read 0 after the next clock edge.
- R2: With `cfg_dual`=0, the pixel presented in a cycle appears on port A (data `{r,g,b}` = bits 23:16,15:8,7:0, flags `{r,g,b}` = bits 2:1:0) after the following rising edge, and port B data and flags are all 0.
- R3: The pixel presented in the cycle where `hsync` is high after being low is odd. The first pixel after reset is odd. Parity alternates on every later pixel.
- R4: With `cfg_dual`=1 and `cfg_odd_on_a`=1, odd pixels go to port A and even pixels to port B. With `cfg_odd_on_a`=0 the assignment is swapped.
- R5: In dual-port mode, each port holds a value for two clocks between loads of a steady pixel stream.
- R6: With `cfg_dual`=1 and `cfg_stagger`=0, both ports load on the edge after the even pixel. The odd pixel is held internally until then.
- R7: With `cfg_dual`=1 and `cfg_stagger`=1, each port loads on the edge after its own pixel, so the two ports never change on the same edge.
- R8: With `cfg_blank`=1, a pixel presented while `hsync` or `clamp` is high has all 24 data bits forced to 0. With `cfg_blank`=0 these pulses leave the data unchanged.
- R9: Out-of-range flags travel with their pixel to whichever port it is steered to, and blanking does not clear them.
- R10: `out_drv` equals the inverse of `oe_n` sampled at the previous edge. `oe_n` has no effect on port data or flags.
- R11: `half_clk` is 1 after an edge that took in an odd pixel and 0 after an edge that took in an even pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 24 | Current pixel `{r,g,b}` |
| ovr_in | input | 3 | Out-of-range flags `{r,g,b}` |
| hsync | input | 1 | Line-sync pulse, active high |
| clamp | input | 1 | Clamp pulse, active high |
| cfg_dual | input | 1 | 1 = two ports, 0 = port A only |
| cfg_odd_on_a | input | 1 | 1 = odd pixels on port A |
| cfg_stagger | input | 1 | 1 = ports update on alternate edges |
| cfg_blank | input | 1 | 1 = zero data during sync/clamp |
| oe_n | input | 1 | Active-low output enable |
| port_a_data | output | 24 | Port A pixel data |
| port_a_ovr | output | 3 | Port A out-of-range flags |
| port_b_data | output | 24 | Port B pixel data |
| port_b_ovr | output | 3 | Port B out-of-range flags |
| half_clk | output | 1 | Pixel-pair phase, half the pixel rate |
| out_drv | output | 1 | 1 = ports driven, 0 = high impedance |

## Verification
The hardest case to reach is a parity restart in the middle of a pixel pair while a blank window covers the pixels around it. In synchronous dual-port mode, the held odd pixel must then be discarded or paired correctly, and a zeroed pixel must still carry its flags. Each configuration run raises `hsync` at an odd offset into the stream, for two cycles, with a `clamp` pulse close after it. This forces a restart on what would have been an even pixel. All sixteen combinations of the four configuration bits run this same sequence against a cycle-level model in the bench.

// File: rtl/pix_demux_pkg.sv
package pix_demux_pkg;
  localparam int DEF_CH_W = 8;
  localparam int DEF_NCH  = 3;

  typedef enum logic {LANE_A = 1'b0, LANE_B = 1'b1} lane_e;
endpackage

// File: rtl/pix_phase.sv
module pix_phase (
  input  logic clk,
  input  logic rst,
  input  logic hsync,
  output logic odd_now,
  output logic half_q
);
  logic hsync_q;
  logic odd_prev;
  logic sync_rise;

  assign sync_rise = hsync & ~hsync_q;
  assign odd_now   = sync_rise | ~odd_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_q  <= 1'b0;
      odd_prev <= 1'b0;
      half_q   <= 1'b0;
    end else begin
      hsync_q  <= hsync;
      odd_prev <= odd_now;
      half_q   <= odd_now;
    end
  end
endmodule

// File: rtl/pix_blanker.sv
module pix_blanker #(
  parameter int CH_W = 8,
  parameter int NCH  = 3,
  localparam int DW  = CH_W * NCH
) (
  input  logic [DW-1:0]  data_in,
  input  logic [NCH-1:0] ovr_in,
  input  logic           kill,
  output logic [DW+NCH-1:0] px_out
);
  logic [DW-1:0] data_z;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign data_z[c*CH_W +: CH_W] = kill ? '0 : data_in[c*CH_W +: CH_W];
  end

  assign px_out = {ovr_in, data_z};
endmodule

// File: rtl/pix_router.sv
module pix_router
  import pix_demux_pkg::*;
#(
  parameter int PW = 27
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_dual,
  input  logic          cfg_odd_on_a,
  input  logic          cfg_stagger,
  input  logic          odd_now,
  input  logic [PW-1:0] px,
  output logic [PW-1:0] a_q,
  output logic [PW-1:0] b_q
);
  logic [PW-1:0] hold_q;
  lane_e         lane;

  assign lane = (odd_now == cfg_odd_on_a) ? LANE_A : LANE_B;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      hold_q <= '0;
    end else if (!cfg_dual) begin
      a_q <= px;
      b_q <= '0;
    end else if (cfg_stagger) begin
      if (lane == LANE_A) a_q <= px;
      else                b_q <= px;
    end else if (odd_now) begin
      hold_q <= px;
    end else if (cfg_odd_on_a) begin
      a_q <= hold_q;
      b_q <= px;
    end else begin
      a_q <= px;
      b_q <= hold_q;
    end
  end
endmodule

// File: rtl/pix_demux_top.sv
module pix_demux_top
  import pix_demux_pkg::*;
#(
  parameter int CH_W = DEF_CH_W,
  parameter int NCH  = DEF_NCH,
  localparam int DW  = CH_W * NCH,
  localparam int PW  = DW + NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DW-1:0]  pix_in,
  input  logic [NCH-1:0] ovr_in,
  input  logic           hsync,
  input  logic           clamp,
  input  logic           cfg_dual,
  input  logic           cfg_odd_on_a,
  input  logic           cfg_stagger,
  input  logic           cfg_blank,
  input  logic           oe_n,
  output logic [DW-1:0]  port_a_data,
  output logic [NCH-1:0] port_a_ovr,
  output logic [DW-1:0]  port_b_data,
  output logic [NCH-1:0] port_b_ovr,
  output logic           half_clk,
  output logic           out_drv
);
  logic          odd_now;
  logic          kill;
  logic [PW-1:0] px;
  logic [PW-1:0] a_q;
  logic [PW-1:0] b_q;

  assign kill = cfg_blank & (hsync | clamp);

  pix_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .hsync   (hsync),
    .odd_now (odd_now),
    .half_q  (half_clk)
  );

  pix_blanker #(.CH_W(CH_W), .NCH(NCH)) u_blank (
    .data_in (pix_in),
    .ovr_in  (ovr_in),
    .kill    (kill),
    .px_out  (px)
  );

  pix_router #(.PW(PW)) u_route (
    .clk          (clk),
    .rst          (rst),
    .cfg_dual     (cfg_dual),
    .cfg_odd_on_a (cfg_odd_on_a),
    .cfg_stagger  (cfg_stagger),
    .odd_now      (odd_now),
    .px           (px),
    .a_q          (a_q),
    .b_q          (b_q)
  );

  always_ff @(posedge clk) begin
    if (rst) out_drv <= 1'b0;
    else     out_drv <= ~oe_n;
  end

  assign port_a_data = a_q[DW-1:0];
  assign port_a_ovr  = a_q[PW-1:DW];
  assign port_b_data = b_q[DW-1:0];
  assign port_b_ovr  = b_q[PW-1:DW];
endmodule

// File: rtl/pix_demux_chk.sv
module pix_demux_chk #(
  parameter int DW  = 24,
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [DW-1:0]  pix_in,
  input logic [NCH-1:0] ovr_in,
  input logic           hsync,
  input logic           clamp,
  input logic           cfg_dual,
  input logic           cfg_stagger,
  input logic           cfg_blank,
  input logic           oe_n,
  input logic [DW-1:0]  port_a_data,
  input logic [NCH-1:0] port_a_ovr,
  input logic [DW-1:0]  port_b_data,
  input logic [NCH-1:0] port_b_ovr,
  input logic           out_drv
);
  assert_single_b_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_dual |=> (port_b_data == '0) && (port_b_ovr == '0));

  assert_single_a_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_dual && !(cfg_blank && (hsync || clamp))) |=> port_a_data == $past(pix_in));

  assert_blank_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_dual && cfg_blank && (hsync || clamp)) |=> port_a_data == '0);

  assert_ovr_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_dual |=> port_a_ovr == $past(ovr_in));

  assert_drive_flag_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_drv == !$past(oe_n));

  assert_stagger_apart_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_dual && cfg_stagger && $past(cfg_dual && cfg_stagger) && !$past(rst))
      |-> !(!$stable({port_a_data, port_a_ovr}) && !$stable({port_b_data, port_b_ovr})));
endmodule

bind pix_demux_top pix_demux_chk #(.DW(DW), .NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pix_in      (pix_in),
  .ovr_in      (ovr_in),
  .hsync       (hsync),
  .clamp       (clamp),
  .cfg_dual    (cfg_dual),
  .cfg_stagger (cfg_stagger),
  .cfg_blank   (cfg_blank),
  .oe_n        (oe_n),
  .port_a_data (port_a_data),
  .port_a_ovr  (port_a_ovr),
  .port_b_data (port_b_data),
  .port_b_ovr  (port_b_ovr),
  .out_drv     (out_drv)
);

// File: tb/pix_demux_top_tb_top.sv
module pix_demux_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] pix_in = '0;
  logic [2:0]  ovr_in = '0;
  logic        hsync = 1'b0, clamp = 1'b0, oe_n = 1'b0;
  logic        cfg_dual = 1'b0, cfg_odd_on_a = 1'b0, cfg_stagger = 1'b0, cfg_blank = 1'b0;
  logic [23:0] port_a_data, port_b_data;
  logic [2:0]  port_a_ovr, port_b_ovr;
  logic        half_clk, out_drv;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model state
  logic [26:0] m_a, m_b, m_hold;
  logic        m_odd_prev, m_hs_prev, m_half, m_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_demux_top dut_i (
    .clk(clk), .rst(rst), .pix_in(pix_in), .ovr_in(ovr_in),
    .hsync(hsync), .clamp(clamp), .cfg_dual(cfg_dual),
    .cfg_odd_on_a(cfg_odd_on_a), .cfg_stagger(cfg_stagger),
    .cfg_blank(cfg_blank), .oe_n(oe_n),
    .port_a_data(port_a_data), .port_a_ovr(port_a_ovr),
    .port_b_data(port_b_data), .port_b_ovr(port_b_ovr),
    .half_clk(half_clk), .out_drv(out_drv)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_a = '0; m_b = '0; m_hold = '0;
    m_odd_prev = 1'b0; m_hs_prev = 1'b0; m_half = 1'b0; m_drv = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; hsync = 1'b0; clamp = 1'b0; oe_n = 1'b0;
    repeat (2) @(posedge clk);
    model_clear();
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one pixel: drive at negedge, predict, sample after the edge
  task automatic step(logic [23:0] d, logic [2:0] o, logic hs, logic cl, logic oen,
                      string dtag);
    logic        rise, odd, blank;
    logic [26:0] px;
    pix_in = d; ovr_in = o; hsync = hs; clamp = cl; oe_n = oen;
    rise  = hs & ~m_hs_prev;
    odd   = rise | ~m_odd_prev;
    blank = cfg_blank & (hs | cl);
    px    = {o, blank ? 24'h0 : d};
    if (!cfg_dual) begin
      m_a = px; m_b = '0;
    end else if (cfg_stagger) begin
      if (odd == cfg_odd_on_a) m_a = px; else m_b = px;
    end else if (odd) begin
      m_hold = px;
    end else if (cfg_odd_on_a) begin
      m_a = m_hold; m_b = px;
    end else begin
      m_a = px; m_b = m_hold;
    end
    m_odd_prev = odd; m_hs_prev = hs; m_half = odd; m_drv = ~oen;
    @(posedge clk);
    #1;
    check({dtag, " R8 portA data"}, {8'h0, port_a_data}, {8'h0, m_a[23:0]});
    check({dtag, " R8 portB data"}, {8'h0, port_b_data}, {8'h0, m_b[23:0]});
    check("R9 portA ovr", {29'h0, port_a_ovr}, {29'h0, m_a[26:24]});
    check("R9 portB ovr", {29'h0, port_b_ovr}, {29'h0, m_b[26:24]});
    check("R11 R3 half_clk", {31'h0, half_clk}, {31'h0, m_half});
    check("R10 out_drv", {31'h0, out_drv}, {31'h0, m_drv});
    @(negedge clk);
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    rst = 1'b1; pix_in = 24'hFFFFFF; ovr_in = 3'h7; oe_n = 1'b0;
    cfg_dual = 1'b1; cfg_stagger = 1'b1;
    @(posedge clk); #1;
    check("R1 portA data", {8'h0, port_a_data}, 32'h0);
    check("R1 portB data", {8'h0, port_b_data}, 32'h0);
    check("R1 ovr", {26'h0, port_a_ovr, port_b_ovr}, 32'h0);
    check("R1 half_clk", {31'h0, half_clk}, 32'h0);
    check("R1 out_drv", {31'h0, out_drv}, 32'h0);
  endtask

  // scenario: one configuration, a fixed stream with a mid-pair sync restart
  task automatic test_combo(logic dual, logic odda, logic shift, logic blk);
    string dtag;
    cfg_dual = dual; cfg_odd_on_a = odda; cfg_stagger = shift; cfg_blank = blk;
    apply_reset();
    if (!dual)      dtag = "R2";
    else if (shift) dtag = "R4 R5 R7";
    else            dtag = "R4 R5 R6";
    for (int i = 0; i < 14; i++) begin
      logic [23:0] d;
      logic [2:0]  o;
      logic        hs, cl, oen;
      d   = {8'(i*16 + 1), 8'(i*7 + 2 + dual), 8'(i*3 + 5 + 2*odda)};
      o   = 3'(i % 5);
      hs  = (i == 5) || (i == 6);
      cl  = (i == 9);
      oen = (i == 8);
      step(d, o, hs, cl, oen, dtag);
    end
  endtask

  initial begin : wdog
    int cyc;
    for (cyc = 0; cyc < WDOG_CYCLES && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    test_reset_state();
    for (int k = 0; k < 16; k++)
      test_combo(k[3], k[2], k[1], k[0]);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule